// File: doc/BRIEF.md
# RGMII Receive Re-Timing Sampler

This block sits between the RGMII receive pads and the MAC. It picks a sampling instant for the receive enable line and the four receive data lines after every edge of the receive clock. It runs on its own timing-adjust clock, which must be faster than the receive clock. The receive clock level enters as an asynchronous input. A two-flop stage synchronizes it, and each change of the synchronized level counts as one receive clock edge.

After each edge an internal counter restarts from zero. When the counter reaches a target value, the five lines are captured. The target comes from a programmed delay field or, in automatic setup mode, from half the measured spacing between the two most recent edges. Any line can be given one extra timing-adjust cycle of delay with a skew bit. A captured nibble appears on the outputs with a one-cycle valid pulse and a flag that tells whether it belongs to a rising or a falling edge. With re-timing disabled, the raw lines are captured directly when the edge is detected.

Top module: `rgmii_rx_retimer`

## Requirements
- R1: While reset is held and right after it is released, `cap_valid`, `cap_rise` and `cap_sig` are all 0.
- R2: With `cfg_enable` = 0, take P0 as the first clock edge after `rx_clk_lvl` changes. The block captures `rx_sig` as seen at edge P2 and holds `cap_valid` high for the single cycle after P2. `cap_valid` is never high except in that cycle.
- R3: The sample counter is cleared by both rising and falling receive clock edges. Count k is reached at clock edge P(3+k).
- R4: With `cfg_enable` = 1 and `cfg_setup` = 0, lines whose skew bit is clear are sampled at P(3+`cfg_delay`). `cap_valid` is high for exactly the one cycle after P(4+`cfg_delay`). `cap_rise` is 1 when the edge took the level to 1 and 0 when it took the level to 0.
- R5: Skew bit i belongs to `rx_sig[i]`, where bit 0 is receive enable, bit 1 is data bit 3, bit 2 is data bit 2, bit 3 is data bit 1 and bit 4 is data bit 0. A line whose skew bit is set is sampled one cycle later, at P(4+target), than the lines whose skew bit is clear.
- R6: Let H be the number of clock cycles between consecutive receive clock edges. When target+1 > H−1, no capture is made for that edge.
- R7: With `cfg_enable` = 1 and `cfg_setup` = 1, the target is floor(H/2), where H is the spacing measured between the two most recent edges. `cfg_delay` is then ignored.
- R8: When the receive clock stops, the counter saturates, and exactly one valid pulse is produced for the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing-adjust clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_clk_lvl | input | 1 | Receive clock level, asynchronous |
| rx_sig | input | 5 | Receive lines: [0] enable, [1..4] data bit 3 down to 0 |
| cfg_enable | input | 1 | 1 = re-timing path, 0 = bypass |
| cfg_setup | input | 1 | 1 = automatic sample point at half the edge spacing |
| cfg_delay | input | 5 | Programmed sample count after each edge |
| cfg_skew | input | 5 | Per-line extra one-cycle delay |
| cap_sig | output | 5 | Captured receive lines |
| cap_valid | output | 1 | One-cycle strobe for each captured nibble |
| cap_rise | output | 1 | 1 = nibble belongs to a rising edge |

## Verification
The hardest case to reach from the ports is automatic setup. Its target depends on an edge spacing measured one interval earlier, so a change in receive clock period only takes effect at the second edge after the change. The bench drives the receive clock level itself, one adjust cycle at a time, and changes `rx_sig` to a distinct pattern on every cycle. From the captured pattern it can tell exactly which cycle each line was sampled in. After a period change it runs two unchecked warm-up half periods before it checks the sample point. It also holds the receive clock still for longer than the counter range, to confirm that a single capture is made.

// File: rtl/rxadj_pkg.sv
package rxadj_pkg;
    typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_kind_e;
endpackage

// File: rtl/rxadj_edge_sync.sv
module rxadj_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o,
    output logic level_o
);
    typedef struct packed {
        logic [2:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[1:0], lvl_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.pipe[1];
    assign edge_o  = s_q.pipe[1] ^ s_q.pipe[2];
endmodule

// File: rtl/rxadj_counter.sv
module rxadj_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] period_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        c_d     = c_q;
        cnt_inc = (c_q.cnt == CNT_MAX) ? CNT_MAX : c_q.cnt + CNT_W'(1);
        if (edge_i) begin
            c_d.cnt    = '0;
            c_d.period = cnt_inc;
        end else begin
            c_d.cnt    = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{cnt: CNT_MAX, period: '0};
        else        c_q <= c_d;
    end

    assign cnt_o    = c_q.cnt;
    assign period_o = c_q.period;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (cnt_o == '0)); // R3
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX)); // R8
endmodule

// File: rtl/rxadj_sampler.sv
module rxadj_sampler
    import rxadj_pkg::*;
#(
    parameter int SIG_W = 5,
    parameter int DLY_W = 5,
    parameter int CNT_W = DLY_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             level_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [SIG_W-1:0] rx_sig_i,
    input  logic             cfg_enable,
    input  logic             cfg_setup,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [SIG_W-1:0] cfg_skew,
    output logic [SIG_W-1:0] cap_sig_o,
    output logic             cap_valid_o,
    output logic             cap_rise_o
);
    typedef struct packed {
        logic [SIG_W-1:0] hold;
        edge_kind_e       kind;
        logic [SIG_W-1:0] cap;
        logic             valid;
        logic             rise;
    } smp_t;

    smp_t s_d, s_q;
    logic [CNT_W-1:0] tgt, tgt_late;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        tgt       = cfg_setup ? (period_i >> 1) : CNT_W'(cfg_delay);
        tgt_late  = tgt + CNT_W'(1);
        if (edge_i) s_d.kind = edge_kind_e'(level_i);
        if (!cfg_enable) begin
            if (edge_i) begin
                s_d.cap   = rx_sig_i;
                s_d.valid = 1'b1;
                s_d.rise  = level_i;
            end
        end else begin
            if (cnt_i == tgt) s_d.hold = rx_sig_i;
            if (cnt_i == tgt_late) begin
                s_d.cap   = (cfg_skew & rx_sig_i) | (~cfg_skew & s_q.hold);
                s_d.valid = 1'b1;
                s_d.rise  = (s_q.kind == EDGE_RISE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{hold: '0, kind: EDGE_FALL, cap: '0, valid: 1'b0, rise: 1'b0};
        else        s_q <= s_d;
    end

    assign cap_sig_o   = s_q.cap;
    assign cap_valid_o = s_q.valid;
    assign cap_rise_o  = s_q.rise;

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && edge_i) |=> (cap_valid_o && cap_sig_o == $past(rx_sig_i))); // R2
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !edge_i) |=> !cap_valid_o); // R2
endmodule

// File: rtl/rgmii_rx_retimer.sv
module rgmii_rx_retimer #(
    parameter int SIG_W = 5,
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_clk_lvl,
    input  logic [SIG_W-1:0] rx_sig,
    input  logic             cfg_enable,
    input  logic             cfg_setup,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [SIG_W-1:0] cfg_skew,
    output logic [SIG_W-1:0] cap_sig,
    output logic             cap_valid,
    output logic             cap_rise
);
    localparam int CNT_W = DLY_W + 1;

    logic             rx_edge, rx_level;
    logic [CNT_W-1:0] cnt, period;

    rxadj_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (rx_clk_lvl),
        .edge_o  (rx_edge),
        .level_o (rx_level)
    );

    rxadj_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (rx_edge),
        .cnt_o    (cnt),
        .period_o (period)
    );

    rxadj_sampler #(.SIG_W(SIG_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_smp (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (rx_edge),
        .level_i     (rx_level),
        .cnt_i       (cnt),
        .period_i    (period),
        .rx_sig_i    (rx_sig),
        .cfg_enable  (cfg_enable),
        .cfg_setup   (cfg_setup),
        .cfg_delay   (cfg_delay),
        .cfg_skew    (cfg_skew),
        .cap_sig_o   (cap_sig),
        .cap_valid_o (cap_valid),
        .cap_rise_o  (cap_rise)
    );
endmodule

// File: tb/tb_rgmii_rx_retimer.sv
`timescale 1ns/1ps
module tb_rgmii_rx_retimer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_clk_lvl = 1'b0;
    logic [4:0] rx_sig = '0;
    logic       cfg_enable = 1'b0;
    logic       cfg_setup = 1'b0;
    logic [4:0] cfg_delay = '0;
    logic [4:0] cfg_skew = '0;
    logic [4:0] cap_sig;
    logic       cap_valid;
    logic       cap_rise;
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rgmii_rx_retimer dut (
        .clk(clk), .rst_n(rst_n), .rx_clk_lvl(rx_clk_lvl), .rx_sig(rx_sig),
        .cfg_enable(cfg_enable), .cfg_setup(cfg_setup), .cfg_delay(cfg_delay),
        .cfg_skew(cfg_skew), .cap_sig(cap_sig), .cap_valid(cap_valid), .cap_rise(cap_rise)
    );

    function automatic logic [4:0] pat(input int n);
        logic [5:0] v;
        v = 6'(n);
        return {5{v[0]}} ^ v[5:1];
    endfunction

    function automatic logic [4:0] mix(input logic [4:0] skew, input int nb);
        return (skew & pat(nb + 1)) | (~skew & pat(nb));
    endfunction

    // Starts at a negedge: toggles the receive clock level, then runs h cycles.
    // nexp = loop index at which the valid pulse is expected (-1 = none).
    task automatic half_cycle(input int h, input bit chk, input int nexp,
                              input logic [4:0] esig, input string req);
        logic erise;
        bit   bad;
        bad        = 1'b0;
        rx_clk_lvl = ~rx_clk_lvl;
        erise      = rx_clk_lvl;
        rx_sig     = pat(0);
        for (int n = 0; n < h; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (chk && !bad) begin
                if (n == nexp) begin
                    if (cap_valid !== 1'b1 || cap_sig !== esig || cap_rise !== erise) begin
                        bad = 1'b1;
                        $display("FAIL %s: cycle %0d valid=%b sig=%b rise=%b, expected valid=1 sig=%b rise=%b",
                                 req, n, cap_valid, cap_sig, cap_rise, esig, erise);
                    end
                end else if (cap_valid !== 1'b0) begin
                    bad = 1'b1;
                    $display("FAIL %s: cycle %0d valid=%b, expected valid=0", req, n, cap_valid);
                end
            end
            rx_sig = pat(n + 1);
        end
        if (chk) begin
            tests++;
            if (bad) fails++;
        end
    endtask

    task automatic t_reset();
        tests++;
        if (cap_valid !== 1'b0 || cap_rise !== 1'b0 || cap_sig !== 5'b0) begin
            fails++;
            $display("FAIL R1: valid=%b rise=%b sig=%b, expected 0 0 00000", cap_valid, cap_rise, cap_sig);
        end
    endtask

    task automatic t_bypass();
        cfg_enable = 1'b0;
        half_cycle(16, 1, 2, pat(2), "R2 bypass rising");
        half_cycle(16, 1, 2, pat(2), "R2 bypass falling");
    endtask

    task automatic t_delay();
        cfg_enable = 1'b1; cfg_setup = 1'b0; cfg_delay = 5'd5; cfg_skew = 5'b0;
        half_cycle(16, 1, 9, pat(8), "R4 delay 5 rising");
        half_cycle(16, 1, 9, pat(8), "R4 delay 5 falling");
        cfg_delay = 5'd0; cfg_skew = 5'b11111;
        half_cycle(16, 1, 4, pat(4), "R3 delay 0 all skewed");
        cfg_skew = 5'b0;
        half_cycle(16, 1, 4, pat(3), "R3 delay 0 falling edge count");
    endtask

    task automatic t_skew();
        cfg_delay = 5'd5; cfg_skew = 5'b00101;
        half_cycle(16, 1, 9, mix(5'b00101, 8), "R5 skew enable and data2");
        cfg_skew = 5'b11010;
        half_cycle(16, 1, 9, mix(5'b11010, 8), "R5 skew data3 data1 data0");
    endtask

    task automatic t_window();
        cfg_skew = 5'b0; cfg_delay = 5'd15;
        half_cycle(16, 1, -1, 5'b0, "R6 delay 15 beyond window");
        cfg_delay = 5'd31;
        half_cycle(16, 1, -1, 5'b0, "R6 delay 31 beyond window");
    endtask

    task automatic t_auto();
        cfg_setup = 1'b1; cfg_delay = 5'd2;
        half_cycle(16, 1, 12, pat(11), "R7 auto period 16");
        half_cycle(12, 0, -1, 5'b0, "warm-up");
        half_cycle(12, 0, -1, 5'b0, "warm-up");
        half_cycle(12, 1, 10, pat(9), "R7 auto period 12");
    endtask

    task automatic t_stop();
        cfg_setup = 1'b0; cfg_delay = 5'd3;
        half_cycle(16, 1, 7, pat(6), "R4 delay 3");
        half_cycle(80, 1, 7, pat(6), "R8 stopped clock single capture");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_delay();
        t_skew();
        t_window();
        t_auto();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule